// File: doc/BRIEF.md
# Oscillator Start-up Timer and Frequency Meter

This block brings a main oscillator up under software control and then measures how fast it runs. Software sets an enable bit and an 8-bit start-up field in a control register. The block first waits for eight slow-clock cycles per unit of that field. It then opens a measurement window that lasts sixteen slow-clock periods. During the window a counter in the main-clock domain counts main-clock cycles.

When the window closes, the main-clock domain captures the count into a holding register and signals this with a toggle handshake. The slow/register domain synchronizes the toggle and then loads the captured value into the status register and raises a ready flag. The holding register stays stable while the handshake is open, so software never sees a value that is only partly updated.

Clearing the enable bit throws away the result and stops any wait or measurement in progress. The analog oscillator is modelled by the main-clock input.

Top module: `osc_freq_meter`

## Requirements
- R1: A register write (`reg_we` high at a rising `slck` edge) loads the enable from `reg_wdata` bit 0 and the start-up field from `reg_wdata` bits 15..8. `ctrl_rdata` returns these two fields at the same bit positions, and every other bit reads 0.
- R2: After the enable is set, the ready flag stays 0 for at least (start-up field × 8) + 16 slow-clock cycles. This covers the start-up wait followed by the full window.
- R3: `stat_rdata` bits 15..0 hold the number of main-clock cycles counted inside a window of 16 slow-clock periods. The window opens on the slow-clock edge after the start-up wait ends.
- R4: Ready (`stat_rdata` bit 16) is 0 whenever the enable is 0 and whenever no measured count is available yet. Ready never reads 1 while the enable reads 0.
- R5: Once the measurement finishes with the enable still set, ready becomes 1 and stays 1 with an unchanged count until the enable is cleared.
- R6: A write that clears the enable forces `stat_rdata` to zero at that same edge. It also stops a wait or measurement in progress, so no later result from that attempt appears. Enabling again starts a fresh, correct measurement.
- R7: The main-clock counter saturates at its all-ones value (0xFFFF at the default width) instead of wrapping.
- R8: A start-up field of zero skips the wait. The window opens on the next slow-clock edge, and ready follows within 40 slow cycles of the enabling write.
- R9: After reset, `ctrl_rdata` and `stat_rdata` both read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| slck | input | 1 | Slow reference clock; also the register clock |
| mck | input | 1 | Main oscillator clock being measured |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 16 | Control write data: bit 0 enable, bits 15..8 start-up field |
| ctrl_rdata | output | 32 | Control register readback |
| stat_rdata | output | 32 | Status: bits 15..0 count, bit 16 ready |

## Verification
The measurement is tried at five main-to-slow frequency ratios: 2, 4, 5, 8 and 16 main cycles per slow period. Different start-up fields go with them. An error in the window length, an off-by-one at the window edges, or a lost capture each produces a distinct wrong count. A second instance with a narrow counter runs on the same clocks, so the saturating behaviour can be told apart from wrapping. Two further cases separate a clean abort from a stale late result: a disable in the middle of a measurement, and a re-enable with a zero start-up field. The time from the enabling write to ready is bounded from both sides, and this shows the ×8 scaling of the start-up field.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_MEAS,
        SEQ_COLLECT,
        SEQ_READY
    } seq_state_e;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_SU_LSB  = 8;
    localparam int STAT_RDY_BIT = 16;

endpackage

// File: rtl/osc_startup_seq.sv
module osc_startup_seq
    import ofm_pkg::*;
#(
    parameter int SU_W     = 8,
    parameter int SU_SHIFT = 3,
    parameter int WIN      = 16
) (
    input  logic            slck,
    input  logic            rst_n,
    input  logic            en,
    input  logic [SU_W-1:0] su_field,
    input  logic            result_done,
    output logic            gate,
    output logic            collect
);

    localparam int WAIT_W = SU_W + SU_SHIFT;
    localparam int WIN_W  = (WIN > 1) ? $clog2(WIN) : 1;

    typedef struct packed {
        seq_state_e        state;
        logic [WAIT_W-1:0] wait_cnt;
        logic [WIN_W-1:0]  win_cnt;
        logic              gate;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (!en) begin
            seq_d.state    = SEQ_IDLE;
            seq_d.wait_cnt = '0;
            seq_d.win_cnt  = '0;
            seq_d.gate     = 1'b0;
        end else begin
            case (seq_q.state)
                SEQ_IDLE: begin
                    if (su_field == '0) begin
                        seq_d.state   = SEQ_MEAS;
                        seq_d.win_cnt = WIN_W'(WIN - 1);
                        seq_d.gate    = 1'b1;
                    end else begin
                        seq_d.state    = SEQ_WAIT;
                        seq_d.wait_cnt = {su_field, {SU_SHIFT{1'b0}}} - 1'b1;
                    end
                end
                SEQ_WAIT: begin
                    if (seq_q.wait_cnt == '0) begin
                        seq_d.state   = SEQ_MEAS;
                        seq_d.win_cnt = WIN_W'(WIN - 1);
                        seq_d.gate    = 1'b1;
                    end else begin
                        seq_d.wait_cnt = seq_q.wait_cnt - 1'b1;
                    end
                end
                SEQ_MEAS: begin
                    if (seq_q.win_cnt == '0) begin
                        seq_d.state = SEQ_COLLECT;
                        seq_d.gate  = 1'b0;
                    end else begin
                        seq_d.win_cnt = seq_q.win_cnt - 1'b1;
                    end
                end
                SEQ_COLLECT: begin
                    if (result_done) seq_d.state = SEQ_READY;
                end
                default: seq_d.state = SEQ_READY;
            endcase
        end
    end

    always_ff @(posedge slck or negedge rst_n) begin
        if (!rst_n) seq_q <= '{state: SEQ_IDLE, wait_cnt: '0, win_cnt: '0, gate: 1'b0};
        else        seq_q <= seq_d;
    end

    assign gate    = seq_q.gate;
    assign collect = (seq_q.state == SEQ_COLLECT);

    // R6: a cleared enable returns the sequencer to idle with the window shut
    p_abort_idle_r6: assert property (@(posedge slck) disable iff (!rst_n)
        !en |=> (seq_q.state == SEQ_IDLE && !seq_q.gate));

    // R2: the window stays shut for the whole start-up wait
    p_wait_no_gate_r2: assert property (@(posedge slck) disable iff (!rst_n)
        (seq_q.state == SEQ_WAIT) |-> !gate);

endmodule

// File: rtl/mck_edge_counter.sv
module mck_edge_counter #(
    parameter int CNT_W = 16
) (
    input  logic             mck,
    input  logic             rst_n,
    input  logic             gate_async,
    input  logic             ack_async,
    output logic [CNT_W-1:0] hold,
    output logic             req
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic             g1;
        logic             g2;
        logic             g3;
        logic             a1;
        logic             a2;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
        logic             req;
    } mc_t;

    mc_t mc_d, mc_q;

    always_comb begin
        mc_d    = mc_q;
        mc_d.g1 = gate_async;
        mc_d.g2 = mc_q.g1;
        mc_d.g3 = mc_q.g2;
        mc_d.a1 = ack_async;
        mc_d.a2 = mc_q.a1;
        if (mc_q.g2) begin
            if (mc_q.cnt != CNT_MAX) mc_d.cnt = mc_q.cnt + 1'b1;
        end else if (mc_q.g3) begin
            if (mc_q.req == mc_q.a2) begin
                mc_d.hold = mc_q.cnt;
                mc_d.req  = ~mc_q.req;
            end
            mc_d.cnt = '0;
        end
    end

    always_ff @(posedge mck or negedge rst_n) begin
        if (!rst_n) mc_q <= '0;
        else        mc_q <= mc_d;
    end

    assign hold = mc_q.hold;
    assign req  = mc_q.req;

    // R7: at full scale the counter holds instead of wrapping
    p_no_wrap_r7: assert property (@(posedge mck) disable iff (!rst_n)
        (mc_q.cnt == CNT_MAX && mc_q.g2) |=> (mc_q.cnt == CNT_MAX));

    // R3: the captured value is stable while the handshake is open
    p_hold_stable_r3: assert property (@(posedge mck) disable iff (!rst_n)
        (mc_q.req != mc_q.a2) |=> $stable(mc_q.hold));

endmodule

// File: rtl/result_sync.sv
module result_sync (
    input  logic slck,
    input  logic rst_n,
    input  logic req_async,
    output logic done,
    output logic ack
);

    typedef struct packed {
        logic r1;
        logic r2;
        logic r3;
    } rs_t;

    rs_t rs_d, rs_q;

    always_comb begin
        rs_d    = rs_q;
        rs_d.r1 = req_async;
        rs_d.r2 = rs_q.r1;
        rs_d.r3 = rs_q.r2;
    end

    always_ff @(posedge slck or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign done = rs_q.r2 ^ rs_q.r3;
    assign ack  = rs_q.r3;

    // R3: each capture yields exactly one load strobe
    p_single_done_r3: assert property (@(posedge slck) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/osc_freq_meter.sv
module osc_freq_meter
    import ofm_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int SU_W     = 8,
    parameter int SU_SHIFT = 3,
    parameter int WIN      = 16
) (
    input  logic        slck,
    input  logic        mck,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [15:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] stat_rdata
);

    typedef struct packed {
        logic            en;
        logic [SU_W-1:0] su;
    } ctrl_t;

    typedef struct packed {
        logic             rdy;
        logic [CNT_W-1:0] count;
    } stat_t;

    ctrl_t ctrl_d, ctrl_q;
    stat_t stat_d, stat_q;

    logic             gate, collect, done, ack, req;
    logic [CNT_W-1:0] hold;
    logic             dis_wr;
    logic             unused_wbits;

    assign unused_wbits = ^reg_wdata[CTRL_SU_LSB-1:1];
    assign dis_wr       = reg_we && !reg_wdata[CTRL_EN_BIT];

    osc_startup_seq #(.SU_W(SU_W), .SU_SHIFT(SU_SHIFT), .WIN(WIN)) u_seq (
        .slck        (slck),
        .rst_n       (rst_n),
        .en          (ctrl_q.en),
        .su_field    (ctrl_q.su),
        .result_done (done),
        .gate        (gate),
        .collect     (collect)
    );

    mck_edge_counter #(.CNT_W(CNT_W)) u_cnt (
        .mck        (mck),
        .rst_n      (rst_n),
        .gate_async (gate),
        .ack_async  (ack),
        .hold       (hold),
        .req        (req)
    );

    result_sync u_sync (
        .slck      (slck),
        .rst_n     (rst_n),
        .req_async (req),
        .done      (done),
        .ack       (ack)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        stat_d = stat_q;
        if (reg_we) begin
            ctrl_d.en = reg_wdata[CTRL_EN_BIT];
            ctrl_d.su = reg_wdata[CTRL_SU_LSB +: SU_W];
        end
        if (dis_wr || !ctrl_q.en) begin
            stat_d = '0;
        end else if (collect && done) begin
            stat_d.rdy   = 1'b1;
            stat_d.count = hold;
        end
    end

    always_ff @(posedge slck or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            stat_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
            stat_q <= stat_d;
        end
    end

    always_comb begin
        ctrl_rdata                       = '0;
        ctrl_rdata[CTRL_EN_BIT]          = ctrl_q.en;
        ctrl_rdata[CTRL_SU_LSB +: SU_W]  = ctrl_q.su;
        stat_rdata                       = '0;
        stat_rdata[STAT_RDY_BIT]         = stat_q.rdy;
        stat_rdata[CNT_W-1:0]            = stat_q.count;
    end

    // R4: ready is never shown with the oscillator disabled
    p_rdy_needs_en_r4: assert property (@(posedge slck) disable iff (!rst_n)
        stat_q.rdy |-> ctrl_q.en);

    // R6: a disabling write empties the status at that edge
    p_dis_clears_r6: assert property (@(posedge slck) disable iff (!rst_n)
        dis_wr |=> (!stat_q.rdy && stat_q.count == '0));

    // R5: ready and count persist while enabled
    p_rdy_holds_r5: assert property (@(posedge slck) disable iff (!rst_n)
        (stat_q.rdy && ctrl_q.en && !dis_wr) |=> (stat_q.rdy && $stable(stat_q.count)));

endmodule

// File: tb/osc_freq_meter_test.sv
`timescale 1ns/1ps
module osc_freq_meter_test;

    localparam int NV = 5;
    localparam int HALF_PS [NV] = '{1000, 500, 2000, 250, 800};
    localparam int SU_TBL  [NV] = '{1, 0, 4, 2, 0};
    localparam int EXP_TBL [NV] = '{64, 128, 32, 256, 80};
    localparam int SAT_W   = 6;
    localparam int SAT_MAX = (1 << SAT_W) - 1;

    logic        slck = 1'b0;
    logic        mck  = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata, stat_rdata, sat_ctrl, sat_stat;
    realtime     mhalf = 1.0;

    int checks = 0;
    int fails  = 0;

    osc_freq_meter uut (
        .slck(slck), .mck(mck), .rst_n(rst_n), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .stat_rdata(stat_rdata)
    );

    osc_freq_meter #(.CNT_W(SAT_W)) uut_sat (
        .slck(slck), .mck(mck), .rst_n(rst_n), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .ctrl_rdata(sat_ctrl), .stat_rdata(sat_stat)
    );

    initial begin
        #0.03;
        forever #4 slck = ~slck;
    end

    initial forever #(mhalf) mck = ~mck;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge slck);
        reg_we    = 1'b1;
        reg_wdata = d;
        @(negedge slck);
        reg_we    = 1'b0;
    endtask

    task automatic wait_ready(output int cyc);
        cyc = 0;
        while (!stat_rdata[16] && cyc < 200) begin
            @(negedge slck);
            cyc++;
        end
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int cyc;
        repeat (3) @(negedge slck);
        // R9: reset state
        chk("R9 ctrl", ctrl_rdata, 32'h0);
        chk("R9 stat", stat_rdata, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge slck);
        chk("R9 stat after release", stat_rdata, 32'h0);

        // R1: field readback, reserved bits read 0
        wr(16'hFFFE);
        chk("R1 readback reserved", ctrl_rdata, 32'h0000_FF00);
        wr(16'h0000);
        chk("R1 cleared", ctrl_rdata, 32'h0);

        // table of frequency ratios and start-up fields
        for (int i = 0; i < NV; i++) begin
            mhalf = HALF_PS[i] / 1000.0;
            repeat (4) @(negedge slck);
            wr(16'(SU_TBL[i] << 8) | 16'h1);
            chk("R1 enable readback", ctrl_rdata, 32'(SU_TBL[i] << 8) | 32'h1);
            if (SU_TBL[i] > 0) begin
                repeat (SU_TBL[i] * 8 - 1) @(negedge slck);
                chk("R2 not ready during wait", 32'(stat_rdata[16]), 32'h0);
            end
            wait_ready(cyc);
            if (SU_TBL[i] > 0) cyc = cyc + SU_TBL[i] * 8 - 1;
            chk("R2 wait lower bound", 32'(cyc >= SU_TBL[i] * 8 + 16), 32'h1);
            if (SU_TBL[i] == 0) chk("R8 zero wait bound", 32'(cyc <= 40), 32'h1);
            chk("R5 ready set", 32'(stat_rdata[16]), 32'h1);
            chk("R3 count", 32'(stat_rdata[15:0]), 32'(EXP_TBL[i]));
            chk("R7 saturated count", 32'(sat_stat[SAT_W-1:0]),
                32'((EXP_TBL[i] > SAT_MAX) ? SAT_MAX : EXP_TBL[i]));
            repeat (10) @(negedge slck);
            chk("R5 ready persists", stat_rdata, 32'h0001_0000 | 32'(EXP_TBL[i]));
            wr(16'h0000);
            chk("R6 disable clears", stat_rdata, 32'h0);
            chk("R4 not ready when disabled", 32'(stat_rdata[16]), 32'h0);
        end

        // R6: abort in the middle of a window, then a fresh run
        mhalf = 0.5;
        repeat (4) @(negedge slck);
        wr(16'h0101);
        repeat (17) @(negedge slck);
        chk("R4 not ready mid window", 32'(stat_rdata[16]), 32'h0);
        wr(16'h0000);
        chk("R6 abort clears", stat_rdata, 32'h0);
        repeat (40) @(negedge slck);
        chk("R6 no stale result", stat_rdata, 32'h0);
        wr(16'h0001);
        wait_ready(cyc);
        chk("R8 re-enable zero wait bound", 32'(cyc <= 40), 32'h1);
        chk("R6 fresh count", stat_rdata, 32'h0001_0080);
        wr(16'h0000);
        chk("R6 final disable", stat_rdata, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule